// File: doc/BRIEF.md
# Frame-Gated Raw Stream Capture

This block sits on a raw sensor or camera data path and decides, word by word, which input words are passed downstream. A frame-valid input marks each frame. A frame is taken only if the arm input is high on the clock where frame-valid first goes high. Once a frame is taken, every word is passed until frame-valid drops. The block does no line or pixel windowing, so the length of a capture is set only by how long frame-valid stays high.

A per-cycle data-valid input can be used as a qualifier when the enable input is high. In that case only cycles with data-valid high are passed. When the enable is low, data-valid is ignored. Every output is registered one clock behind the input that caused it. Alongside the data and its strobe, the block gives a start marker with the first word passed in a frame and an end marker for the clock where frame-valid falls.

Top module: `raw_capture_gate`

## Requirements
- R1: After reset all outputs are 0. If frame-valid is already high when reset is released, that is not a rising edge, so the frame already in progress is not captured.
- R2: If `arm_in` is 1 on the clock where `fv_in` is 1 after a clock with `fv_in` at 0, that frame is captured. The word present on that clock appears on the outputs with `cap_valid_out`=1 one clock later.
- R3: When `cap_valid_out` is 1, `cap_data_out` equals the `data_in` of the previous clock. When `cap_valid_out` is 0, `cap_data_out` keeps its last value.
- R4: With `qual_en_in`=1, a clock with `dv_in`=0 inside a captured frame produces `cap_valid_out`=0 one clock later. Data-valid has no effect while frame-valid is low.
- R5: With `qual_en_in`=0, `dv_in` is ignored and every clock with `fv_in`=1 inside a captured frame is passed.
- R6: `cap_sof_out` is 1 together with the first passed word of each captured frame and is 0 otherwise. With the qualifier enabled, this first word may come after the rising edge.
- R7: `cap_eof_out` is 1 for exactly one clock, one clock after the first clock with `fv_in`=0 that follows a captured frame, and `cap_valid_out` is 0 on that clock. The end marker is raised even when the qualifier passed no word in that frame.
- R8: If `arm_in` is 0 at the rising edge, nothing of that high period is passed and no end marker is raised, even if `arm_in` goes high partway through the period.
- R9: Frames whose high and low periods each last one clock are each captured and ended correctly when they come back to back.
- R10: `arm_in` is only looked at on the rising edge. Dropping it during a captured frame does not stop the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fv_in | input | 1 | Frame-valid from the source |
| dv_in | input | 1 | Data-valid from the source |
| data_in | input | DATA_W | Raw data word |
| arm_in | input | 1 | Acquisition armed; sampled on the frame-valid rising edge |
| qual_en_in | input | 1 | 1 = pass only cycles with data-valid high |
| cap_data_out | output | DATA_W | Captured word; holds its value between captures |
| cap_valid_out | output | 1 | Captured-word strobe |
| cap_sof_out | output | 1 | First captured word of a frame |
| cap_eof_out | output | 1 | Frame ended (frame-valid fell) |

## Verification
The hardest cases to reach are the ones where frame-valid toggles every clock. Here a rising edge, a falling edge and the end marker of the previous frame all fall on neighbouring clocks, and this is where a wrong edge-detector reset value or a stale capture flag would show up. The stimulus table drives one-clock frames back to back, with the arm input both high and low. It also arms a frame partway through its high period, and enables the qualifier on a frame whose rising-edge clock has data-valid low. A directed test holds frame-valid high through the release of reset. This shows that a frame already under way is not mistaken for a new one.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

    // Frame tracking state
    typedef struct packed {
        logic active;   // inside a captured frame
        logic pend;     // start marker not yet issued in this frame
    } rcg_ctl_t;

    // Per-cycle decision handed to the output stage
    typedef struct packed {
        logic take;
        logic sof;
        logic eof;
    } rcg_evt_t;

endpackage

// File: rtl/rcg_edge_det.sv
module rcg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic fv_in,
    output logic rise_o
);
    // Resets high so that a frame that is already running at reset release is not seen as a start.
    logic fv_d, fv_q;

    always_comb begin
        fv_d   = fv_in;
        rise_o = fv_in & ~fv_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fv_q <= 1'b1;
        else        fv_q <= fv_d;
    end
endmodule

// File: rtl/rcg_frame_ctl.sv
module rcg_frame_ctl
    import rcg_pkg::*;
#(
    parameter bit QUAL_SUPPORT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rise_i,
    input  logic     fv_in,
    input  logic     arm_in,
    input  logic     dv_in,
    input  logic     qual_en_in,
    output rcg_evt_t evt_o
);
    rcg_ctl_t ctl_d, ctl_q;
    logic     qual_ok;

    generate
        if (QUAL_SUPPORT) begin : g_qual
            assign qual_ok = ~qual_en_in | dv_in;
        end else begin : g_noqual
            logic unused_qual;
            assign unused_qual = qual_en_in ^ dv_in;
            assign qual_ok     = 1'b1;
        end
    endgenerate

    always_comb begin
        logic start, live, pend_now;
        start    = rise_i & arm_in;
        live     = fv_in & (start | ctl_q.active);
        pend_now = start | ctl_q.pend;

        evt_o.take = live & qual_ok;
        evt_o.sof  = evt_o.take & pend_now;
        evt_o.eof  = ~fv_in & ctl_q.active;

        ctl_d.active = live;
        ctl_d.pend   = live & pend_now & ~evt_o.take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/rcg_out_stage.sv
module rcg_out_stage
    import rcg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rcg_evt_t          evt_i,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              sof_o,
    output logic              eof_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              sof;
        logic              eof;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = evt_i.take;
        out_d.sof   = evt_i.sof;
        out_d.eof   = evt_i.eof;
        if (evt_i.take) out_d.data = data_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign data_o  = out_q.data;
    assign valid_o = out_q.valid;
    assign sof_o   = out_q.sof;
    assign eof_o   = out_q.eof;
endmodule

// File: rtl/raw_capture_gate.sv
module raw_capture_gate
    import rcg_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter bit QUAL_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fv_in,
    input  logic              dv_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              arm_in,
    input  logic              qual_en_in,
    output logic [DATA_W-1:0] cap_data_out,
    output logic              cap_valid_out,
    output logic              cap_sof_out,
    output logic              cap_eof_out
);
    logic     rise;
    rcg_evt_t evt;

    rcg_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .fv_in  (fv_in),
        .rise_o (rise)
    );

    rcg_frame_ctl #(.QUAL_SUPPORT(QUAL_SUPPORT)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .fv_in      (fv_in),
        .arm_in     (arm_in),
        .dv_in      (dv_in),
        .qual_en_in (qual_en_in),
        .evt_o      (evt)
    );

    rcg_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .data_in (data_in),
        .data_o  (cap_data_out),
        .valid_o (cap_valid_out),
        .sof_o   (cap_sof_out),
        .eof_o   (cap_eof_out)
    );
endmodule

// File: rtl/raw_capture_gate_chk.sv
module raw_capture_gate_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fv_in,
    input logic              dv_in,
    input logic [DATA_W-1:0] data_in,
    input logic              qual_en_in,
    input logic [DATA_W-1:0] cap_data_out,
    input logic              cap_valid_out,
    input logic              cap_sof_out,
    input logic              cap_eof_out
);
    AST_VALID_NEEDS_FV: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_out |-> $past(fv_in)); // R2
    AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_out |-> cap_data_out == $past(data_in)); // R3
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid_out |-> $stable(cap_data_out)); // R3
    AST_QUAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_out && $past(qual_en_in)) |-> $past(dv_in)); // R4
    AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cap_sof_out |-> cap_valid_out); // R6
    AST_EOF_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        cap_eof_out |-> (!cap_valid_out && !$past(fv_in))); // R7
    AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_eof_out |=> !cap_eof_out); // R7
endmodule

bind raw_capture_gate raw_capture_gate_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fv_in         (fv_in),
    .dv_in         (dv_in),
    .data_in       (data_in),
    .qual_en_in    (qual_en_in),
    .cap_data_out  (cap_data_out),
    .cap_valid_out (cap_valid_out),
    .cap_sof_out   (cap_sof_out),
    .cap_eof_out   (cap_eof_out)
);

// File: tb/test_raw_capture_gate.sv
module test_raw_capture_gate;
    localparam int DW = 8;
    localparam int NV = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fv_in = 1'b0, dv_in = 1'b0, arm_in = 1'b0, qual_en_in = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic [DW-1:0] cap_data_out;
    logic          cap_valid_out, cap_sof_out, cap_eof_out;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    raw_capture_gate #(.DATA_W(DW)) i_raw_capture_gate (
        .clk(clk), .rst_n(rst_n), .fv_in(fv_in), .dv_in(dv_in), .data_in(data_in),
        .arm_in(arm_in), .qual_en_in(qual_en_in), .cap_data_out(cap_data_out),
        .cap_valid_out(cap_valid_out), .cap_sof_out(cap_sof_out), .cap_eof_out(cap_eof_out)
    );

    // {fv,dv,arm,qen, data, valid,sof,eof, exp_data, req}
    localparam logic [26:0] VEC [NV] = '{
        {4'b0010, 8'h11, 3'b000, 8'h00, 4'd1},  // R1 idle
        {4'b1010, 8'h21, 3'b110, 8'h21, 4'd2},  // R2 armed rise, R5 dv ignored
        {4'b1100, 8'h22, 3'b100, 8'h22, 4'd10}, // R10 arm dropped
        {4'b1000, 8'h23, 3'b100, 8'h23, 4'd5},  // R5
        {4'b0100, 8'h24, 3'b001, 8'h23, 4'd7},  // R7 end, R3 hold
        {4'b0000, 8'h25, 3'b000, 8'h23, 4'd3},  // R3
        {4'b1000, 8'h31, 3'b000, 8'h23, 4'd8},  // R8 unarmed rise
        {4'b1010, 8'h32, 3'b000, 8'h23, 4'd8},  // R8 armed mid-frame
        {4'b0010, 8'h33, 3'b000, 8'h23, 4'd8},  // R8 no end marker
        {4'b1011, 8'h41, 3'b000, 8'h23, 4'd4},  // R4 rise with dv low
        {4'b1101, 8'h42, 3'b110, 8'h42, 4'd6},  // R6 first qualified word
        {4'b1001, 8'h43, 3'b000, 8'h42, 4'd4},  // R4
        {4'b1101, 8'h44, 3'b100, 8'h44, 4'd4},  // R4
        {4'b0101, 8'h45, 3'b001, 8'h44, 4'd7},  // R7, R4 dv while fv low
        {4'b1110, 8'h51, 3'b110, 8'h51, 4'd9},  // R9 one-clock frame
        {4'b0010, 8'h52, 3'b001, 8'h51, 4'd9},  // R9
        {4'b1010, 8'h53, 3'b110, 8'h53, 4'd9},  // R9 back to back
        {4'b0000, 8'h54, 3'b001, 8'h53, 4'd9},  // R9
        {4'b1000, 8'h55, 3'b000, 8'h53, 4'd8},  // R8 one-clock unarmed
        {4'b0000, 8'h56, 3'b000, 8'h53, 4'd8}   // R8
    };

    task automatic check(input string req, input logic [10:0] got, input logic [10:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got v/s/e/data=%b/%b/%b/%h expected %b/%b/%b/%h", req,
                     got[10], got[9], got[8], got[7:0], exp[10], exp[9], exp[8], exp[7:0]);
        end
    endtask

    function automatic logic [10:0] outs();
        return {cap_valid_out, cap_sof_out, cap_eof_out, cap_data_out};
    endfunction

    initial begin : watchdog
        #2000000;
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        #1 check("R1 in reset", outs(), 11'b0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {fv_in, dv_in, arm_in, qual_en_in} = VEC[i][26:23];
            data_in = VEC[i][22:15];
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VEC[i][3:0], i), outs(), VEC[i][14:4]);
        end

        // R7: qualifier on, no dv in frame -> end marker without start
        {fv_in, dv_in, arm_in, qual_en_in} = 4'b1011; data_in = 8'h61;
        @(negedge clk); check("R7 no-word frame body", outs(), {3'b000, 8'h53});
        {fv_in, arm_in} = 2'b00;
        @(negedge clk); check("R7 end without start", outs(), {3'b001, 8'h53});

        // R1: reset while frame-valid high, release with it still high
        fv_in = 1'b1; arm_in = 1'b1; qual_en_in = 1'b0; data_in = 8'h71;
        @(negedge clk); check("R2 armed frame before reset", outs(), {3'b110, 8'h71});
        rst_n = 1'b0;
        #1 check("R1 async reset clears", outs(), 11'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); check("R1 running frame ignored", outs(), 11'b0);
        @(negedge clk); check("R1 running frame ignored 2", outs(), 11'b0);
        fv_in = 1'b0;
        @(negedge clk); check("R1 no end marker", outs(), 11'b0);
        fv_in = 1'b1; data_in = 8'h72;
        @(negedge clk); check("R2 capture after reset", outs(), {3'b110, 8'h72});
        fv_in = 1'b0;
        @(negedge clk); check("R7 end after reset", outs(), {3'b001, 8'h72});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule